// File: doc/BRIEF.md
# Radix-4 trace-back survivor memory

This block sits behind a radix-4 add-compare-select array in a convolutional decoder. Each radix-4 step, the array hands it one decision vector holding a two-bit survivor choice for every trellis state. The vectors go into a circular memory. The block then recovers the decoded data by walking the survivor path backwards, and emits the bits in their original time order.

The memory holds `MERGE_LEN + 2*DEC_LEN` vectors and is used as three rotating regions:

- one region of `DEC_LEN` entries that is being filled;
- one region of `MERGE_LEN` entries that is walked only to let the survivor paths converge;
- one region of `DEC_LEN` entries whose walk yields data.

Once every `DEC_LEN` writes, after the first `MERGE_LEN + DEC_LEN`, the walk starts afresh from state 0 at the newest entry. Each step it forms the earlier state by shifting the stored two-bit choice into the low end of the state index. The two bits that leave the top are that step's data.

The walk produces data newest first. A small last-in first-out stack turns it back into time order before it leaves the block. The source must space its writes so that one walk, and the draining of its stack, ends before the next batch of `DEC_LEN` writes completes. That is at least `MERGE_LEN + 2*DEC_LEN + 1` cycles per batch.

Top module: `tbk_traceback`

## Requirements
- R1: After reset `out_valid` is 0. No output appears before `MERGE_LEN + DEC_LEN` decision vectors have been written.
- R2: A vector is stored only in a cycle where `dec_valid` is 1. The content of `dec_vec` in other cycles has no effect on the decoded output. State x's two-bit choice sits in `dec_vec[2x+1:2x]`.
- R3: The walk begins at state 0 on the newest vector. At each step the earlier state is `{cur[STATE_BITS-3:0], choice}`, where `choice` is the field read for `cur`. The step's decoded pair is `cur[STATE_BITS-1:STATE_BITS-2]`.
- R4: A walk is launched at the write that brings the total to `MERGE_LEN + DEC_LEN`, and then at every further `DEC_LEN`-th write. Each walk yields exactly `DEC_LEN` output pairs.
- R5: Output pairs leave oldest first. The k-th pair ever emitted is the data of the k-th step written, counting from 0.
- R6: Addresses wrap modulo `MERGE_LEN + 2*DEC_LEN`. A continuous stream decodes correctly across any number of wraps, with no entry overwritten before it is read.
- R7: The `DEC_LEN` pairs of one walk appear on `DEC_LEN` consecutive cycles with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decision vector is present on `dec_vec` |
| dec_vec | input | 2*2**STATE_BITS | Two-bit survivor choice per state, state x at bits 2x+1:2x |
| out_valid | output | 1 | `out_bits` carries a decoded pair |
| out_bits | output | 2 | Decoded data pair for one radix-4 step |

## Verification
The bench builds the block with 16 states, a merge depth of 6 and a decode length of 4. The memory is then 14 entries, so a 200-step stream wraps the addresses about fourteen times and exercises every region boundary many times over.

It drives choices that are correct only for states on or converging onto the true path, and random elsewhere. A walk that reads the wrong field or shifts the wrong way therefore loses the path. Garbage is driven on the vector while the strobe is low.

With the short merge depth, the first launch and a launch landing on the address wrap both fall within a few dozen cycles.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  // Phase of the trace-back walk.
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_MERGE,
    PH_DECODE,
    PH_DRAIN
  } tbk_phase_e;

endpackage

// File: rtl/tbk_decision_mem.sv
module tbk_decision_mem #(
  parameter int SB = 5,
  parameter int L  = 30,
  parameter int D  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2*(1<<SB)-1:0]       wr_data,
  input  logic [$clog2(L+2*D)-1:0]   rd_addr,
  output logic [2*(1<<SB)-1:0]       rd_data,
  output logic                       trig,
  output logic [$clog2(L+2*D)-1:0]   trig_addr
);
  localparam int W  = 2 * (1 << SB);
  localparam int N  = L + 2 * D;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(L + D + 1);

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return (a == AW'(N - 1)) ? '0 : a + 1'b1;
  endfunction

  logic [W-1:0]  mem [N];
  logic [AW-1:0] wp;
  logic [CW-1:0] till;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      till <= CW'(L + D - 1);
    end else if (wr_en) begin
      wp   <= addr_after(wp);
      till <= (till == '0) ? CW'(D - 1) : till - 1'b1;
    end
  end

  assign trig      = wr_en && (till == '0);
  assign trig_addr = wp;
  assign rd_data   = mem[rd_addr];

  // R6: the write pointer never leaves the memory.
  a_r6_wp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wp < AW'(N)));

endmodule

// File: rtl/tbk_lifo.sv
module tbk_lifo #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] stack [DEPTH];
  logic [PW-1:0]    sp;
  logic [PW-1:0]    top_idx;

  assign top_idx = sp - 1'b1;
  assign empty   = (sp == '0);

  always_ff @(posedge clk) begin
    if (push) stack[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop;
      if (push) begin
        sp <= sp + 1'b1;
      end else if (pop) begin
        sp       <= top_idx;
        out_data <= stack[top_idx];
      end
    end
  end

  // R5: the stack neither overflows nor underflows.
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sp < PW'(DEPTH)));
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r5_no_push_and_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/tbk_trace_engine.sv
module tbk_trace_engine
  import tbk_pkg::*;
#(
  parameter int SB = 5,
  parameter int L  = 30,
  parameter int D  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig,
  input  logic [$clog2(L+2*D)-1:0]   trig_addr,
  output logic [$clog2(L+2*D)-1:0]   rd_addr,
  input  logic [2*(1<<SB)-1:0]       rd_data,
  input  logic                       lifo_empty,
  output logic                       push,
  output logic [1:0]                 push_bits,
  output logic                       pop
);
  localparam int N  = L + 2 * D;
  localparam int AW = $clog2(N);
  localparam int KW = $clog2(((L > D) ? L : D) + 1);

  function automatic logic [AW-1:0] addr_before(input logic [AW-1:0] a);
    return (a == '0) ? AW'(N - 1) : a - 1'b1;
  endfunction

  function automatic logic [1:0] choice_of(input logic [2*(1<<SB)-1:0] vec,
                                           input logic [SB-1:0] s);
    return vec[{s, 1'b0} +: 2];
  endfunction

  function automatic logic [SB-1:0] earlier_state(input logic [SB-1:0] cur,
                                                  input logic [1:0] c);
    return {cur[SB-3:0], c};
  endfunction

  tbk_phase_e    ph;
  logic [AW-1:0] rp;
  logic [SB-1:0] st;
  logic [KW-1:0] cnt;

  // Named internal events.
  logic [1:0] cur_choice;
  logic       walking;
  logic       phase_end;

  assign cur_choice = choice_of(rd_data, st);
  assign walking    = (ph == PH_MERGE) || (ph == PH_DECODE);
  assign phase_end  = (ph == PH_MERGE) ? (cnt == KW'(L - 1)) : (cnt == KW'(D - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      rp  <= '0;
      st  <= '0;
      cnt <= '0;
    end else begin
      if (walking) begin
        st <= earlier_state(st, cur_choice);
        rp <= addr_before(rp);
      end
      case (ph)
        PH_IDLE: begin
          if (trig) begin
            rp  <= trig_addr;
            st  <= '0;
            cnt <= '0;
            ph  <= PH_MERGE;
          end
        end
        PH_MERGE, PH_DECODE, PH_DRAIN: begin
          if (phase_end) begin
            cnt <= '0;
            ph  <= (ph == PH_MERGE)  ? PH_DECODE :
                   (ph == PH_DECODE) ? PH_DRAIN  : PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign rd_addr   = rp;
  assign push      = (ph == PH_DECODE);
  assign push_bits = st[SB-1:SB-2];
  assign pop       = (ph == PH_DRAIN);

  // R4: a launch only arrives while the walk is idle (source spacing contract).
  a_r4_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (ph == PH_IDLE));

  // R7: the drain leaves the stack empty.
  a_r7_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DRAIN && phase_end) |=> lifo_empty);

  // R3: the walk starts from state 0 at the launch address.
  a_r3_start_state_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && trig) |=> (push_bits == 2'b00 && rd_addr == $past(trig_addr)));

endmodule

// File: rtl/tbk_traceback.sv
module tbk_traceback #(
  parameter int STATE_BITS = 5,
  parameter int MERGE_LEN  = 30,
  parameter int DEC_LEN    = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dec_valid,
  input  logic [2*(1<<STATE_BITS)-1:0]   dec_vec,
  output logic                           out_valid,
  output logic [1:0]                     out_bits
);
  localparam int W  = 2 * (1 << STATE_BITS);
  localparam int AW = $clog2(MERGE_LEN + 2 * DEC_LEN);
  localparam int CW = $clog2(MERGE_LEN + DEC_LEN + 1);

  logic          trig;
  logic [AW-1:0] trig_addr;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data;
  logic          push;
  logic [1:0]    push_bits;
  logic          pop;
  logic          lifo_empty;

  tbk_decision_mem #(.SB(STATE_BITS), .L(MERGE_LEN), .D(DEC_LEN)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dec_valid),
    .wr_data   (dec_vec),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .trig      (trig),
    .trig_addr (trig_addr)
  );

  tbk_trace_engine #(.SB(STATE_BITS), .L(MERGE_LEN), .D(DEC_LEN)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .trig_addr  (trig_addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .lifo_empty (lifo_empty),
    .push       (push),
    .push_bits  (push_bits),
    .pop        (pop)
  );

  tbk_lifo #(.DEPTH(DEC_LEN), .WIDTH(2)) u_lifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_bits),
    .pop       (pop),
    .out_valid (out_valid),
    .out_data  (out_bits),
    .empty     (lifo_empty)
  );

  // Saturating count of written vectors, kept for the early-output check.
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (dec_valid && seen != CW'(MERGE_LEN + DEC_LEN)) seen <= seen + 1'b1;
  end

  // R1: nothing leaves before MERGE_LEN + DEC_LEN vectors were written.
  a_r1_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen == CW'(MERGE_LEN + DEC_LEN)));

endmodule

// File: tb/tb_tbk_traceback.sv
`timescale 1ns/1ps
module tb_tbk_traceback;
  localparam int SB    = 4;
  localparam int L     = 6;
  localparam int D     = 4;
  localparam int NS    = 1 << SB;
  localparam int W     = 2 * NS;
  localparam int NSTEP = 200;
  localparam int GMIN  = (L + 2 * D + 1 + D - 1) / D;
  localparam int NOUT  = ((NSTEP - (L + D)) / D + 1) * D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dec_valid = 1'b0;
  logic [W-1:0] dec_vec = '0;
  logic         out_valid;
  logic [1:0]   out_bits;

  int errors = 0;
  int checks = 0;
  int writes = 0;
  int outcnt = 0;
  int run    = 0;
  bit done   = 1'b0;
  logic [1:0] u_hist [NSTEP];

  always #2.5 clk = ~clk;

  tbk_traceback #(.STATE_BITS(SB), .MERGE_LEN(L), .DEC_LEN(D)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_vec(dec_vec),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  // Forward path model: the newest pair enters at the top of the state.
  function automatic logic [SB-1:0] next_state(input logic [SB-1:0] s, input logic [1:0] u);
    return {u, s[SB-1:2]};
  endfunction

  // The choice is right for states that a walk can reach, random elsewhere.
  function automatic logic [W-1:0] make_vec(input logic [SB-1:0] s_new,
                                            input logic [SB-1:0] s_old);
    logic [W-1:0] v;
    for (int x = 0; x < NS; x++) begin
      if (x[1:0] == s_new[1:0] || x == 0) v[2*x +: 2] = s_old[1:0];
      else                                v[2*x +: 2] = 2'($urandom);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0, "R1 out_valid during reset", int'(out_valid), 0);
    end else begin
      if (out_valid) begin
        if (outcnt == 0)
          check(writes >= L + D, "R1 R4 first output after L+D writes", writes, L + D);
        if (outcnt < NSTEP)
          check(out_bits == u_hist[outcnt], "R2 R3 R5 R6 decoded pair in order",
                int'(out_bits), int'(u_hist[outcnt]));
        outcnt++;
        run++;
      end else if (run != 0) begin
        check(run == D, "R7 consecutive pairs per walk", run, D);
        run = 0;
      end
    end
  end

  initial begin
    logic [SB-1:0] s_old;
    logic [SB-1:0] s_new;
    logic [1:0]    u;
    int            gap;
    void'($urandom(32'd1234));
    s_old = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int n = 0; n < NSTEP; n++) begin
      if (n < 4)                       u = 2'b11;
      else if (n >= 60 && n < 64)      u = 2'b00;
      else                             u = 2'($urandom);
      u_hist[n] = u;
      s_new = next_state(s_old, u);
      @(negedge clk);
      dec_valid = 1'b1;
      dec_vec   = make_vec(s_new, s_old);
      writes++;
      s_old = s_new;
      gap = GMIN + int'($urandom % 3);
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        dec_valid = 1'b0;
        dec_vec   = {W{1'b1}} ^ W'($urandom);
      end
      if (gap == 1) begin
        @(negedge clk);
        dec_valid = 1'b0;
      end
    end
    @(negedge clk);
    dec_valid = 1'b0;
    repeat (L + 2 * D + 10) @(negedge clk);
    check(outcnt == NOUT, "R4 total pairs emitted", outcnt, NOUT);
    check(out_valid == 1'b0, "R7 quiet after the last walk", int'(out_valid), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual %0d expected %0d", outcnt, NOUT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule